// File: doc/BRIEF.md
# ISA-Style I/O Cycle Sequencer

This block is a bus master for 8-bit and 16-bit I/O transfers on an ISA-style expansion bus. An internal client gives it an address, a direction flag and write data, and pulses a start strobe. The sequencer then runs one complete bus cycle. It pulses the address latch strobe and drives the address. It waits out the address setup time, then samples the target's 16-bit select line to choose the transfer width. It asserts the active-low read or write command and holds that command for the minimum pulse width, longer if the target pulls the ready line low. It releases the command, keeps the address and write data valid for a hold period, and pulses a done strobe together with the captured read data.

All timing is counted in cycles of one internal clock. Each minimum time is a parameter that has been rounded up to whole cycles for a 20 ns clock. Two configuration inputs add whole cycles: a command delay input adds to the address setup time, and a wait input adds to the command pulse. When both are zero, the bus cycle has its default timing. A ready line that stays low is cut off by a timeout, which ends the cycle and sets a sticky error flag. A separate active-low enable drives the data transceivers. It turns on one cycle after the command starts and stays on for a fixed number of cycles after the command ends.

Top module: `isa_io_seq`

## Requirements
- R1: A start strobe is accepted only when the sequencer is idle. A start strobe during a running cycle is ignored. Each accepted request gives exactly one `req_done` pulse, which lasts one clock.
- R2: On acceptance, `bale` goes high for ALE_CYC (3) cycles. `sa` carries the request address from the same edge. No command is active while `bale` is high.
- R3: The command becomes active SETUP_WR (10) cycles after `bale` rises for a write, or SETUP_RD (8) cycles after it rises for a read. The value of `cfg_cmd_dly` adds cycles to this delay.
- R4: `iocs16_n` is sampled on the edge that starts the command. Low selects a 16-bit transfer, so `req_rdata` carries all of `sd_in`. High selects an 8-bit transfer, so bits 15:8 of `req_rdata` are zero.
- R5: A write drives only `iow_n` low and a read drives only `ior_n` low. Without a ready stretch, the command lasts PW_WR (8) cycles for a write or PW_RD (12) cycles for a read, plus `cfg_wait` cycles.
- R6: `iochrdy` sampled low during the first WIN_WR (2) cycles of a write command, or the first WIN_RD (4) cycles of a read command, stretches the command. A low `iochrdy` later in the command is ignored.
- R7: After a stretch, the command stays active for HOLD_WR (6) cycles after `iochrdy` is sampled high again on a write, or HOLD_RD (8) cycles on a read. In no case is the command shorter than the width given in R5.
- R8: If `iochrdy` stays low for TMO_CYC (32) cycles of a stretch, the command is released and `bus_err` is set. `bus_err` stays set until reset.
- R9: After the command is released, `sa` keeps its value and write data stays driven (`sd_oe` high) for AHOLD (3) cycles. `req_done` then pulses.
- R10: Read data is captured from `sd_in` on the edge that releases the command. It is presented on `req_rdata` while `req_done` is high.
- R11: `dbufoe_n` goes low one cycle after the command starts. It returns high OE_HOLD (3) cycles after the command ends.
- R12: After reset, `bale`, `req_done`, `bus_err` and `sd_oe` are low, and `ior_n`, `iow_n` and `dbufoe_n` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start strobe for one bus cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | I/O address |
| req_wdata | input | 16 | Write data |
| cfg_cmd_dly | input | 4 | Extra address setup cycles |
| cfg_wait | input | 4 | Extra command cycles |
| req_done | output | 1 | One-cycle completion pulse |
| req_rdata | output | 16 | Captured read data |
| bus_err | output | 1 | Sticky ready-timeout flag |
| bale | output | 1 | Address latch strobe |
| sa | output | 16 | Bus address |
| ior_n | output | 1 | Active-low read command |
| iow_n | output | 1 | Active-low write command |
| dbufoe_n | output | 1 | Active-low data buffer enable |
| sd_out | output | 16 | Write data to the bus |
| sd_oe | output | 1 | Write data drive enable |
| sd_in | input | 16 | Read data from the bus |
| iocs16_n | input | 1 | Active-low 16-bit target select |
| iochrdy | input | 1 | Target ready; low stretches the command |

## Verification
Every timing result is a count of clock cycles measured from a bus event:

- `bale` width and address-to-command delay are counted from the `bale` rise.
- Pulse width, ready window and ready hold are counted from the command's falling edge.
- Buffer-enable turn-on is counted from the command start, buffer-enable hold from the command release, and address hold up to `req_done`.

A monitor samples every falling clock edge and counts the cycles in which each condition holds. Each count is compared with a value worked out from the cycle numbers in the requirements, so the result does not depend on when the bench issued the request. The ready line is driven on falling edges at a chosen cycle of the command. The design therefore sees a ready change at the next rising edge, and the windows in R6 map directly onto cycle numbers.

// File: rtl/isa_seq_pkg.sv
package isa_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ALE, ST_SETUP, ST_CMD, ST_WAIT, ST_HOLD, ST_RECOV, ST_DONE
  } seq_state_e;
endpackage

// File: rtl/isa_seq_lim.sv
// Selects the per-direction phase lengths and folds in the configuration extras.
module isa_seq_lim #(
  parameter int CW       = 8,
  parameter int CFGW     = 4,
  parameter int SETUP_WR = 10,
  parameter int SETUP_RD = 8,
  parameter int PW_WR    = 8,
  parameter int PW_RD    = 12,
  parameter int WIN_WR   = 2,
  parameter int WIN_RD   = 4,
  parameter int HOLD_WR  = 6,
  parameter int HOLD_RD  = 8
) (
  input  logic            is_wr,
  input  logic [CFGW-1:0] cfg_dly,
  input  logic [CFGW-1:0] cfg_wait,
  output logic [CW-1:0]   setup_len,
  output logic [CW-1:0]   pw_len,
  output logic [CW-1:0]   win_len,
  output logic [CW-1:0]   hold_len
);
  always_comb begin
    if (is_wr) begin
      setup_len = CW'(SETUP_WR) + CW'(cfg_dly);
      pw_len    = CW'(PW_WR) + CW'(cfg_wait);
      win_len   = CW'(WIN_WR);
      hold_len  = CW'(HOLD_WR);
    end else begin
      setup_len = CW'(SETUP_RD) + CW'(cfg_dly);
      pw_len    = CW'(PW_RD) + CW'(cfg_wait);
      win_len   = CW'(WIN_RD);
      hold_len  = CW'(HOLD_RD);
    end
  end
endmodule

// File: rtl/isa_seq_oe.sv
// Buffer enable shaper: on one cycle after the command, off OE_HOLD cycles after it ends.
module isa_seq_oe #(
  parameter int OE_HOLD = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic cmd_act,
  output logic oe_n
);
  localparam int OW = $clog2(OE_HOLD + 1);
  logic [OW-1:0] hc;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_n <= 1'b1;
      hc   <= '0;
    end else if (cmd_act) begin
      oe_n <= 1'b0;
      hc   <= '0;
    end else if (!oe_n) begin
      if (hc == OW'(OE_HOLD - 1)) begin
        oe_n <= 1'b1;
        hc   <= '0;
      end else begin
        hc <= hc + 1'b1;
      end
    end
  end
endmodule

// File: rtl/isa_io_seq.sv
module isa_io_seq #(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int CFGW     = 4,
  parameter int ALE_CYC  = 3,
  parameter int SETUP_WR = 10,
  parameter int SETUP_RD = 8,
  parameter int PW_WR    = 8,
  parameter int PW_RD    = 12,
  parameter int WIN_WR   = 2,
  parameter int WIN_RD   = 4,
  parameter int HOLD_WR  = 6,
  parameter int HOLD_RD  = 8,
  parameter int AHOLD    = 3,
  parameter int OE_HOLD  = 3,
  parameter int TMO_CYC  = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_start,
  input  logic            req_wr,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  input  logic [CFGW-1:0] cfg_cmd_dly,
  input  logic [CFGW-1:0] cfg_wait,
  output logic            req_done,
  output logic [DW-1:0]   req_rdata,
  output logic            bus_err,
  output logic            bale,
  output logic [AW-1:0]   sa,
  output logic            ior_n,
  output logic            iow_n,
  output logic            dbufoe_n,
  output logic [DW-1:0]   sd_out,
  output logic            sd_oe,
  input  logic [DW-1:0]   sd_in,
  input  logic            iocs16_n,
  input  logic            iochrdy
);
  import isa_seq_pkg::*;

  localparam int CW = $clog2(TMO_CYC + PW_RD + HOLD_RD + SETUP_WR + 2 * (1 << CFGW) + 8);
  localparam int TW = $clog2(TMO_CYC + 1);
  localparam int HW = DW / 2;

  seq_state_e        state;
  logic [CW-1:0]     cnt;
  logic [CW-1:0]     hcnt;
  logic [TW-1:0]     tcnt;
  logic              wr_q;
  logic              wide_q;
  logic [CW-1:0]     setup_len, pw_len, win_len, hold_len;
  logic              cmd_act;
  logic              rel_go;
  logic              rel_err;

  isa_seq_lim #(
    .CW(CW), .CFGW(CFGW),
    .SETUP_WR(SETUP_WR), .SETUP_RD(SETUP_RD),
    .PW_WR(PW_WR), .PW_RD(PW_RD),
    .WIN_WR(WIN_WR), .WIN_RD(WIN_RD),
    .HOLD_WR(HOLD_WR), .HOLD_RD(HOLD_RD)
  ) lim_i (
    .is_wr(wr_q), .cfg_dly(cfg_cmd_dly), .cfg_wait(cfg_wait),
    .setup_len(setup_len), .pw_len(pw_len), .win_len(win_len), .hold_len(hold_len)
  );

  assign cmd_act = !ior_n || !iow_n;

  isa_seq_oe #(.OE_HOLD(OE_HOLD)) oe_i (
    .clk(clk), .rst(rst), .cmd_act(cmd_act), .oe_n(dbufoe_n)
  );

  // Release decision for the three command states.
  always_comb begin
    rel_go  = 1'b0;
    rel_err = 1'b0;
    case (state)
      ST_CMD:  rel_go = !(cnt < win_len && !iochrdy) && (cnt == pw_len - 1'b1);
      ST_WAIT: begin
        rel_err = !iochrdy && (tcnt == TW'(TMO_CYC - 1));
        rel_go  = rel_err;
      end
      ST_HOLD: rel_go = (hcnt >= hold_len - 1'b1) && (cnt >= pw_len - 1'b1);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      hcnt      <= '0;
      tcnt      <= '0;
      wr_q      <= 1'b0;
      wide_q    <= 1'b0;
      bale      <= 1'b0;
      sa        <= '0;
      ior_n     <= 1'b1;
      iow_n     <= 1'b1;
      sd_out    <= '0;
      sd_oe     <= 1'b0;
      req_done  <= 1'b0;
      req_rdata <= '0;
      bus_err   <= 1'b0;
    end else begin
      req_done <= 1'b0;
      if (rel_err) bus_err <= 1'b1;
      if (rel_go) begin
        ior_n     <= 1'b1;
        iow_n     <= 1'b1;
        req_rdata <= wide_q ? sd_in : {{(DW-HW){1'b0}}, sd_in[HW-1:0]};
        cnt       <= '0;
        state     <= ST_RECOV;
      end else begin
        case (state)
          ST_IDLE: if (req_start) begin
            sa     <= req_addr;
            wr_q   <= req_wr;
            sd_out <= req_wdata;
            sd_oe  <= req_wr;
            bale   <= 1'b1;
            cnt    <= '0;
            state  <= ST_ALE;
          end
          ST_ALE: begin
            if (cnt == CW'(ALE_CYC - 1)) begin
              bale  <= 1'b0;
              cnt   <= '0;
              state <= ST_SETUP;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_SETUP: begin
            if (cnt == setup_len - CW'(ALE_CYC) - 1'b1) begin
              wide_q <= !iocs16_n;
              if (wr_q) iow_n <= 1'b0;
              else      ior_n <= 1'b0;
              cnt   <= '0;
              state <= ST_CMD;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_CMD: begin
            cnt <= cnt + 1'b1;
            if (cnt < win_len && !iochrdy) begin
              tcnt  <= '0;
              state <= ST_WAIT;
            end
          end
          ST_WAIT: begin
            cnt  <= cnt + 1'b1;
            tcnt <= tcnt + 1'b1;
            if (iochrdy) begin
              hcnt  <= '0;
              state <= ST_HOLD;
            end
          end
          ST_HOLD: begin
            cnt  <= cnt + 1'b1;
            hcnt <= hcnt + 1'b1;
          end
          ST_RECOV: begin
            if (cnt == CW'(AHOLD - 1)) begin
              req_done <= 1'b1;
              state    <= ST_DONE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          ST_DONE: begin
            sd_oe <= 1'b0;
            state <= ST_IDLE;
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/isa_io_seq_chk.sv
module isa_io_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          bale,
  input logic          ior_n,
  input logic          iow_n,
  input logic          dbufoe_n,
  input logic [AW-1:0] sa,
  input logic          req_done,
  input logic          bus_err
);
  a_r5_one_cmd: assert property (@(posedge clk) disable iff (rst) ior_n || iow_n);
  a_r2_bale_no_cmd: assert property (@(posedge clk) disable iff (rst) bale |-> (ior_n && iow_n));
  a_r11_oe_late: assert property (@(posedge clk) disable iff (rst)
    ($fell(ior_n) || $fell(iow_n)) |-> dbufoe_n);
  a_r11_oe_hold: assert property (@(posedge clk) disable iff (rst)
    ($rose(ior_n) || $rose(iow_n)) |-> !dbufoe_n);
  a_r9_sa_stable: assert property (@(posedge clk) disable iff (rst)
    (!ior_n || !iow_n || $rose(ior_n) || $rose(iow_n)) |-> $stable(sa));
  a_r1_done_pulse: assert property (@(posedge clk) disable iff (rst) req_done |=> !req_done);
  a_r9_done_idle: assert property (@(posedge clk) disable iff (rst) req_done |-> (ior_n && iow_n));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (rst) bus_err |=> bus_err);
endmodule

bind isa_io_seq isa_io_seq_chk #(.AW(AW)) chk_i (
  .clk(clk), .rst(rst), .bale(bale), .ior_n(ior_n), .iow_n(iow_n),
  .dbufoe_n(dbufoe_n), .sa(sa), .req_done(req_done), .bus_err(bus_err)
);

// File: tb/isa_io_seq_tb_top.sv
module isa_io_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_start = 1'b0;
  logic        req_wr = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [3:0]  cfg_cmd_dly = '0;
  logic [3:0]  cfg_wait = '0;
  logic        req_done;
  logic [15:0] req_rdata;
  logic        bus_err;
  logic        bale;
  logic [15:0] sa;
  logic        ior_n, iow_n, dbufoe_n;
  logic [15:0] sd_out;
  logic        sd_oe;
  logic [15:0] sd_in = 16'hA5C3;
  logic        iocs16_n = 1'b0;
  logic        iochrdy = 1'b1;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  // monitor state
  int  bale_cnt, setup_cnt, pw_cnt, oe_dly, oe_hold, ahold_cnt, done_cnt;
  bit  started, cmd_seen, done_seen, rd_seen, wr_seen, sd_oe_at_done;
  logic [15:0] sa_at_done, rdata_at_done;
  int  rdy_fall, rdy_len;

  always #4 clk = ~clk;

  isa_io_seq dut_i (
    .clk(clk), .rst(rst), .req_start(req_start), .req_wr(req_wr),
    .req_addr(req_addr), .req_wdata(req_wdata), .cfg_cmd_dly(cfg_cmd_dly),
    .cfg_wait(cfg_wait), .req_done(req_done), .req_rdata(req_rdata),
    .bus_err(bus_err), .bale(bale), .sa(sa), .ior_n(ior_n), .iow_n(iow_n),
    .dbufoe_n(dbufoe_n), .sd_out(sd_out), .sd_oe(sd_oe), .sd_in(sd_in),
    .iocs16_n(iocs16_n), .iochrdy(iochrdy)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Falling-edge monitor; also plays the target's ready line.
  always @(negedge clk) begin
    if (bale) begin bale_cnt++; started = 1; end
    if (started && !cmd_seen && ior_n && iow_n) setup_cnt++;
    if (!ior_n) rd_seen = 1;
    if (!iow_n) wr_seen = 1;
    if (!ior_n || !iow_n) begin
      cmd_seen = 1;
      pw_cnt++;
      if (dbufoe_n) oe_dly++;
      if (pw_cnt == rdy_fall) iochrdy = 1'b0;
      if (pw_cnt == rdy_fall + rdy_len) iochrdy = 1'b1;
    end else if (cmd_seen) begin
      if (!dbufoe_n) oe_hold++;
      if (!req_done && !done_seen) ahold_cnt++;
    end
    if (req_done) begin
      done_cnt++;
      done_seen = 1;
      sa_at_done = sa;
      rdata_at_done = req_rdata;
      sd_oe_at_done = sd_oe;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clr_mon();
    bale_cnt = 0; setup_cnt = 0; pw_cnt = 0; oe_dly = 0; oe_hold = 0;
    ahold_cnt = 0; done_cnt = 0; started = 0; cmd_seen = 0; done_seen = 0;
    rd_seen = 0; wr_seen = 0; sd_oe_at_done = 0; sa_at_done = '0; rdata_at_done = '0;
  endtask

  task automatic run_io(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input bit cs16, input int fall, input int len, input int poke_at);
    clr_mon();
    rdy_fall = fall;
    rdy_len  = len;
    iocs16_n = !cs16;
    @(negedge clk);
    req_wr = wr; req_addr = a; req_wdata = d; req_start = 1'b1;
    @(negedge clk);
    req_start = 1'b0;
    for (int i = 0; i < 400 && !done_seen; i++) begin
      @(negedge clk);
      if (i == poke_at) begin
        req_addr = a ^ 16'hFFFF; req_wr = !wr; req_start = 1'b1;
      end else begin
        req_start = 1'b0;
      end
    end
    req_start = 1'b0;
    repeat (6) @(negedge clk);
    iochrdy = 1'b1;
    rdy_fall = 0;
  endtask

  task automatic t_reset();
    chk("R12 bale", int'(bale), 0);
    chk("R12 ior_n", int'(ior_n), 1);
    chk("R12 iow_n", int'(iow_n), 1);
    chk("R12 dbufoe_n", int'(dbufoe_n), 1);
    chk("R12 done", int'(req_done), 0);
    chk("R12 err", int'(bus_err), 0);
    chk("R12 sd_oe", int'(sd_oe), 0);
  endtask

  task automatic t_wr16();
    run_io(1, 16'h0300, 16'h1234, 1, 0, 0, -1);
    chk("R2 bale width", bale_cnt, 3);
    chk("R3 write setup", setup_cnt, 10);
    chk("R5 write pulse", pw_cnt, 8);
    chk("R5 no ior on write", int'(rd_seen), 0);
    chk("R11 oe delay", oe_dly, 1);
    chk("R11 oe hold", oe_hold, 3);
    chk("R9 addr hold", ahold_cnt, 3);
    chk("R9 sa at done", int'(sa_at_done), 16'h0300);
    chk("R9 write data driven", int'(sd_oe_at_done), 1);
    chk("R1 one done", done_cnt, 1);
  endtask

  task automatic t_rd8();
    sd_in = 16'hA5C3;
    run_io(0, 16'h0060, 16'h0, 0, 0, 0, -1);
    chk("R3 read setup", setup_cnt, 8);
    chk("R5 read pulse", pw_cnt, 12);
    chk("R5 no iow on read", int'(wr_seen), 0);
    chk("R4 8-bit rdata", int'(rdata_at_done), 16'h00C3);
    chk("R11 read oe hold", oe_hold, 3);
  endtask

  task automatic t_rd16();
    sd_in = 16'h5A3C;
    run_io(0, 16'h0170, 16'h0, 1, 0, 0, -1);
    chk("R10 R4 16-bit rdata", int'(rdata_at_done), 16'h5A3C);
    chk("R9 read addr hold", ahold_cnt, 3);
  endtask

  task automatic t_stretch();
    run_io(1, 16'h0310, 16'hBEEF, 1, 1, 5, -1);
    chk("R6 R7 write stretch", pw_cnt, 12);
    run_io(0, 16'h0320, 16'h0, 1, 2, 3, -1);
    chk("R6 R7 read stretch", pw_cnt, 13);
    run_io(0, 16'h0330, 16'h0, 1, 5, 3, -1);
    chk("R6 late ready ignored", pw_cnt, 12);
    run_io(1, 16'h0340, 16'h0, 1, 3, 3, -1);
    chk("R6 late write ready ignored", pw_cnt, 8);
    run_io(0, 16'h0350, 16'h0, 1, 1, 1, -1);
    chk("R7 min width kept", pw_cnt, 12);
  endtask

  task automatic t_cfg();
    cfg_cmd_dly = 4'd2;
    run_io(0, 16'h0360, 16'h0, 1, 0, 0, -1);
    chk("R3 cmd delay", setup_cnt, 10);
    cfg_cmd_dly = 4'd0;
    cfg_wait = 4'd3;
    run_io(1, 16'h0370, 16'h0, 1, 0, 0, -1);
    chk("R5 wait states", pw_cnt, 11);
    cfg_wait = 4'd0;
  endtask

  task automatic t_busy();
    run_io(1, 16'h0280, 16'h00AA, 1, 0, 0, 4);
    chk("R1 busy start ignored done", done_cnt, 1);
    chk("R1 busy start addr kept", int'(sa_at_done), 16'h0280);
    chk("R1 busy start no read", int'(rd_seen), 0);
  endtask

  task automatic t_timeout();
    run_io(0, 16'h0390, 16'h0, 1, 1, 1000, -1);
    chk("R8 timeout pulse", pw_cnt, 33);
    chk("R8 err set", int'(bus_err), 1);
    run_io(1, 16'h03A0, 16'h0, 1, 0, 0, -1);
    chk("R8 err sticky", int'(bus_err), 1);
    chk("R8 normal after timeout", pw_cnt, 8);
  endtask

  initial begin
    rdy_fall = 0; rdy_len = 0;
    clr_mon();
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_wr16();
    t_rd8();
    t_rd16();
    t_stretch();
    t_cfg();
    t_busy();
    t_timeout();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule